// File: doc/BRIEF.md
# Free-Running Timer with Output-Compare Channels

The block holds one up-counter that runs on every clock from zero to a programmable top value and then returns to zero. Around it sit a parameterised number of compare channels. Each channel keeps a compare value, an enable and an action code. When the counter holds the channel's compare value, the channel drives its output pin high, drives it low, inverts it, or leaves it alone, and it raises a sticky event flag. The counter's return to zero raises a separate sticky flag. Each flag drives an interrupt line through its own enable bit.

Software reaches the block through a write-only port (enable, address, data). Compare values have no shadow copy. A write replaces the value in use on the next clock. A write placed badly within a period can therefore drop that period's compare, or give a second compare in the same period. The block keeps this behaviour on purpose, and it is stated exactly below.

Top module: `ocmp_timer`

## Requirements
- R1: After reset the count is 0, the top value is all ones, every pin and every flag is 0, every channel is disabled and every interrupt enable is 0.
- R2: While the count is below the top value it rises by one per clock. In the cycle after the count is at or above the top value, the count is 0. A top value written below the current count therefore wraps the counter on the following clock. The top value is written at address 0.
- R3: The overflow flag (bit 0 of the flag layout) becomes 1 on the same clock edge that returns the counter to 0.
- R4: The control word of channel k is written at address 5+2k, with bit 0 as the enable and bits 2:1 as the action. On a match, the action sets the pin as follows: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. The new pin level is visible one clock after the counter shows the compare value.
- R5: A disabled channel never changes its pin or its flag.
- R6: The compare flag of channel k (flag bit 1+k) becomes 1 one clock after the counter equals an enabled channel's compare value. The compare value is written at address 4+2k.
- R7: Flags stay set until a write of 1 to their bit at address 1. Bits written 0 leave their flags unchanged. When a set and a clear land on the same clock, the flag stays set.
- R8: Address 2 holds the interrupt enables, with the same bit layout as the flags. Each interrupt output is 1 exactly when its flag and its enable are both 1.
- R9: A compare write takes effect at once. A new value below the current count, written before the old value was reached, gives no compare for the rest of that period.
- R10: A larger compare value written after a compare event, within the same period, gives a second compare in that period.
- R11: When a compare write and a match on the old value fall on the same clock, the match on the old value still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| cnt_o | output | CNT_W | Current counter value |
| pin_o | output | N_CH | Compare output pins, one per channel |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | N_CH | Sticky compare flags |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cmp_irq_o | output | N_CH | Compare interrupt requests |

## Verification
The bench sets a top value of 9 and sweeps every action code against compare values at the bottom, the middle and the top of the period. It checks the pin one clock after the match. A design that evaluated the match a cycle late, or that mixed up two action codes, would show the wrong pin level. The bench moves a compare value below the count before the old value is reached and expects silence until the next period. It also raises a compare value just after a match and expects a second event in the same period. A design with a hidden shadow register would fail both of these checks. The bench also lines up a compare write, and separately a flag clear, with a match on the same clock, to confirm that the old value matches and that a set wins over a clear.

// File: rtl/tim_oc_pkg.sv
package tim_oc_pkg;
   typedef enum logic [1:0] {
      OC_HOLD   = 2'b00,
      OC_TOGGLE = 2'b01,
      OC_CLEAR  = 2'b10,
      OC_SET    = 2'b11
   } oc_act_e;

   localparam int unsigned OC_MOD_ADDR = 0;
   localparam int unsigned OC_CLR_ADDR = 1;
   localparam int unsigned OC_IEN_ADDR = 2;
   localparam int unsigned OC_CH_BASE  = 4;
endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_we,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mod_q;

   assign wrap_o = (cnt_q >= mod_q);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mod_q <= '1;
      end else begin
         cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
         if (mod_we) mod_q <= wr_data;
      end
   end

   // R2: counting and wrapping
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0));
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_o |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/oc_flag.sv
module oc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R7: sticky, and set wins over clear
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import tim_oc_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_we,
   input  logic             ctl_we,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             match_o,
   output logic             pin_o
);
   logic [CNT_W-1:0] cmp_q;
   logic             en_q;
   oc_act_e          act_q;
   logic             pin_q;
   logic             pin_d;

   assign match_o = en_q && (cnt_i == cmp_q);

   always_comb begin
      pin_d = pin_q;
      if (match_o) begin
         case (act_q)
            OC_TOGGLE: pin_d = ~pin_q;
            OC_CLEAR:  pin_d = 1'b0;
            OC_SET:    pin_d = 1'b1;
            default:   pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         en_q  <= 1'b0;
         act_q <= OC_HOLD;
         pin_q <= 1'b0;
      end else begin
         pin_q <= pin_d;
         if (cmp_we) cmp_q <= wr_data;
         if (ctl_we) begin
            en_q  <= wr_data[0];
            act_q <= oc_act_e'(wr_data[2:1]);
         end
      end
   end

   assign pin_o = pin_q;

   // R5: disabled channel holds its pin
   assert_idle_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(pin_q));
   // R4: set and clear actions
   assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && act_q == OC_SET) |=> pin_q);
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && act_q == OC_CLEAR) |=> !pin_q);
   assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && act_q == OC_TOGGLE) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
   import tim_oc_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned N_CH   = 2,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [N_CH-1:0]   pin_o,
   output logic              ovf_flag_o,
   output logic [N_CH-1:0]   cmp_flag_o,
   output logic              ovf_irq_o,
   output logic [N_CH-1:0]   cmp_irq_o
);
   localparam int unsigned N_FLAG   = N_CH + 1;
   localparam int unsigned ADDR_MIN = $clog2(OC_CH_BASE + 2 * N_CH);

   if (N_CH < 1) begin : g_bad_nch
      $error("ocmp_timer: N_CH must be at least 1");
   end
   if (CNT_W < N_FLAG || CNT_W < 3) begin : g_bad_cntw
      $error("ocmp_timer: CNT_W too narrow for flag and control words");
   end
   if (ADDR_W < ADDR_MIN) begin : g_bad_addrw
      $error("ocmp_timer: ADDR_W too narrow for the channel count");
   end

   logic              wrap;
   logic [N_FLAG-1:0] set_vec;
   logic [N_FLAG-1:0] clr_vec;
   logic [N_FLAG-1:0] flag_vec;
   logic [N_FLAG-1:0] ien_q;
   logic              clr_hit;

   assign clr_hit = wr_en && (wr_addr == ADDR_W'(OC_CLR_ADDR));
   assign clr_vec = clr_hit ? wr_data[N_FLAG-1:0] : '0;

   oc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .mod_we (wr_en && (wr_addr == ADDR_W'(OC_MOD_ADDR))),
      .wr_data(wr_data),
      .cnt_o  (cnt_o),
      .wrap_o (wrap)
   );

   assign set_vec[0] = wrap;

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      oc_channel #(.CNT_W(CNT_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .cmp_we (wr_en && (wr_addr == ADDR_W'(OC_CH_BASE + 2 * k))),
         .ctl_we (wr_en && (wr_addr == ADDR_W'(OC_CH_BASE + 2 * k + 1))),
         .wr_data(wr_data),
         .cnt_i  (cnt_o),
         .match_o(set_vec[k+1]),
         .pin_o  (pin_o[k])
      );
   end

   for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
      oc_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[f]),
         .clr_i (clr_vec[f]),
         .flag_o(flag_vec[f])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ien_q <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(OC_IEN_ADDR))) ien_q <= wr_data[N_FLAG-1:0];
   end

   assign ovf_flag_o = flag_vec[0];
   assign cmp_flag_o = flag_vec[N_FLAG-1:1];
   assign ovf_irq_o  = flag_vec[0] & ien_q[0];
   assign cmp_irq_o  = flag_vec[N_FLAG-1:1] & ien_q[N_FLAG-1:1];

   // R3: overflow flag follows the wrap
   assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (ovf_flag_o && cnt_o == '0));
   // R8: no interrupt without its flag
   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq_o |-> ovf_flag_o);
   // R6: a match raises the channel flag
   assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[1] |=> cmp_flag_o[0]);
endmodule

// File: tb/ocmp_timer_tb.sv
module ocmp_timer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam int N_CH = 2;
   localparam int ADDR_W = 3;
   localparam int TOP = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [CNT_W-1:0]  cnt_o;
   logic [N_CH-1:0]   pin_o;
   logic              ovf_flag_o;
   logic [N_CH-1:0]   cmp_flag_o;
   logic              ovf_irq_o;
   logic [N_CH-1:0]   cmp_irq_o;

   int checks = 0;
   int errors = 0;

   ocmp_timer #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_o(cnt_o), .pin_o(pin_o), .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o),
      .ovf_irq_o(ovf_irq_o), .cmp_irq_o(cmp_irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int addr, input int data);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(addr);
      wr_data = CNT_W'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_cnt(input int v);
      for (int n = 0; n < 100 && cnt_o != CNT_W'(v); n++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic p;
      logic seen;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cnt_o == 0 && pin_o == 0 && cmp_flag_o == 0 && !ovf_flag_o && cmp_irq_o == 0 && !ovf_irq_o,
          "R1", int'(cnt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cnt_o == 1, "R1 count from zero", int'(cnt_o), 1);

      // R2/R3: program top value, sweep one full period
      wr(0, TOP);
      wait_cnt(4);
      wr(1, 1);
      chk(!ovf_flag_o, "R7 overflow cleared", int'(ovf_flag_o), 0);
      wait_cnt(0);
      for (int i = 0; i <= TOP; i++) begin
         chk(cnt_o == CNT_W'(i), "R2 count sweep", int'(cnt_o), i);
         @(negedge clk);
      end
      chk(cnt_o == 0, "R2 wrap", int'(cnt_o), 0);
      chk(ovf_flag_o, "R3 overflow on wrap", int'(ovf_flag_o), 1);

      // R5: channel 1 holds compare but stays disabled with a set action
      wr(6, 3);
      wr(7, 6);

      // R4/R6: every action against several compare positions
      for (int a = 0; a < 4; a++) begin
         for (int j = 0; j < 3; j++) begin
            int cv;
            logic expv;
            cv = (j == 0) ? 0 : (j == 1) ? 4 : TOP;
            wait_cnt((cv + 4) % (TOP + 1));
            wr(4, cv);
            wr(5, (a << 1) | 1);
            wr(1, 2);
            wait_cnt(cv);
            chk(!cmp_flag_o[0], "R6 no flag before match", int'(cmp_flag_o[0]), 0);
            p = pin_o[0];
            @(negedge clk);
            expv = (a == 0) ? p : (a == 1) ? ~p : (a == 2) ? 1'b0 : 1'b1;
            chk(pin_o[0] == expv, $sformatf("R4 action %0d at %0d", a, cv), int'(pin_o[0]), int'(expv));
            chk(cmp_flag_o[0], "R6 flag on match", int'(cmp_flag_o[0]), 1);
            chk(!pin_o[1] && !cmp_flag_o[1], "R5 disabled channel idle", int'(pin_o[1]), 0);
         end
      end

      // R9: lowering the value past the count drops this period's compare
      wr(5, 3);               // toggle, enabled
      wait_cnt(1);
      wr(4, 8);
      wr(1, 2);
      wait_cnt(6);
      wr(4, 3);
      seen = 1'b0;
      while (cnt_o != 0) begin
         seen |= cmp_flag_o[0];
         @(negedge clk);
      end
      seen |= cmp_flag_o[0];
      chk(!seen, "R9 missed compare", int'(seen), 0);
      wait_cnt(4);
      chk(cmp_flag_o[0], "R9 compare in next period", int'(cmp_flag_o[0]), 1);

      // R10: raising the value after a match gives a second match
      wait_cnt(0);
      wr(4, 2);
      wr(1, 2);
      p = pin_o[0];
      @(negedge clk);
      chk(cmp_flag_o[0] && pin_o[0] == ~p, "R10 first compare", int'(pin_o[0]), int'(~p));
      wr(4, 7);
      wr(1, 2);
      chk(!cmp_flag_o[0], "R7 flag cleared", int'(cmp_flag_o[0]), 0);
      wait_cnt(8);
      chk(cmp_flag_o[0] && pin_o[0] == p, "R10 second compare same period", int'(pin_o[0]), int'(p));

      // R11: write on the match clock still matches the old value
      wait_cnt(0);
      wr(4, 5);
      wr(1, 2);
      wait_cnt(5);
      wr(4, 1);
      chk(cmp_flag_o[0], "R11 old value matched", int'(cmp_flag_o[0]), 1);

      // R7: clear landing on a match clock loses to the set
      wait_cnt(1);
      wr(1, 2);
      chk(cmp_flag_o[0], "R7 set wins over clear", int'(cmp_flag_o[0]), 1);
      wait_cnt(0);
      wait_cnt(3);
      wr(1, 2);
      chk(!cmp_flag_o[0] && ovf_flag_o, "R7 bitwise clear", int'(ovf_flag_o), 1);

      // R8: interrupt gating
      wait_cnt(0);
      wait_cnt(2);
      wr(2, 0);
      chk(cmp_flag_o[0] && cmp_irq_o == 0 && !ovf_irq_o, "R8 masked", int'(cmp_irq_o), 0);
      wr(2, 7);
      chk(cmp_irq_o == 2'b01 && ovf_irq_o, "R8 enabled", int'(cmp_irq_o), 1);

      // R2: top value written below the count
      wait_cnt(7);
      wr(0, 3);
      chk(cnt_o == 8, "R2 count before wrap", int'(cnt_o), 8);
      @(negedge clk);
      chk(cnt_o == 0, "R2 wrap above new top", int'(cnt_o), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule